// File: doc/BRIEF.md
# External Interrupt Combiner

This block produces the external interrupt request for a small CPU. Its sources are one dedicated active-low interrupt pin and a group of general-purpose port pins (four by default). Each port pin has its own static enable. An enabled port pin is merged with the dedicated pin, so a low level on any enabled source pulls the combined interrupt source low. Port pins whose enable is clear have no influence.

Every pin is asynchronous to the CPU clock, so each one passes through its own two-flop synchronizer. A falling edge of the synchronized combined source sets a pending latch. A one-cycle acknowledge from the CPU clears that latch. One static mode input sets the sensitivity for every merged source. In edge mode, only falling edges cause a request. In level mode, a source that stays low keeps the request asserted even after an acknowledge. A CPU global mask blocks the request output but leaves the latch unchanged.

Top module: `extIntCombiner`

## Requirements
- R1: After reset, with all pins high, `irqReq` is 0 and stays 0. Reset puts no edge into the pending latch.
- R2: In edge mode (`levelMode`=0), when the combined source goes from high to low, `irqReq` rises at the third rising clock edge after the pin change. It is still 0 after the second edge.
- R3: In edge mode, a source held low after an acknowledge does not assert the request again. A rising edge on the source never sets the request.
- R4: In level mode (`levelMode`=1), `irqReq` is 1 from the second rising edge after the combined source goes low. It stays 1 through an acknowledge for as long as the source is low.
- R5: Port pin k joins the combined source only when `portEn[k]`=1. A port pin that is low while its enable is 0 leaves `irqReq` at 0.
- R6: The mode chosen by `levelMode` applies to the enabled port pins in the same way as to `irqPinN`.
- R7: An `ack` pulse with no coinciding falling edge clears the pending latch. In edge mode, `irqReq` is 0 at the next clock edge.
- R8: While `cpuMask`=1, `irqReq` is 0. A pending request that was latched before or during the mask appears again once `cpuMask` returns to 0.
- R9: A falling edge of the combined source that is detected in the same cycle as `ack` leaves the pending latch set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Active-low asynchronous reset |
| irqPinN | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| portPinN | input | NUM_PORT | Port pins that can be merged, active low, asynchronous |
| portEn | input | NUM_PORT | Static per-pin merge enables |
| levelMode | input | 1 | 0: falling edge only; 1: falling edge plus low level |
| cpuMask | input | 1 | Global interrupt mask from the CPU |
| ack | input | 1 | One-cycle acknowledge that clears the pending latch |
| irqReq | output | 1 | Interrupt request to the CPU |

## Verification
The in-line assertions check the following on every cycle: the mask always blocks the output; edge mode never asserts without a pending latch; a low source in level mode always asserts an unmasked request; the latch only sets after the source was low; and a detected edge always lands in the latch, even during an acknowledge. Some behaviours show up only in the bench scenarios. These are the exact three-cycle and two-cycle latencies, the effect of the per-pin enables, the absence of re-assertion in edge mode after acknowledge, and a masked request returning. The bench sweeps every enable pattern against every port pin in both modes for these.

// File: rtl/extint_pkg.sv
package extint_pkg;
  // strobes from the edge controller to the pending latch
  typedef struct packed {
    logic setPend;
    logic clrPend;
  } pendStrobe_t;
endpackage

// File: rtl/extIntControl.sv
module extIntControl
  import extint_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        srcLow,
  input  logic        ack,
  output pendStrobe_t strobe
);
  logic prevLow;
  logic fallSeen;

  // previous level resets to "not low", so a high source after reset yields no edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLow <= 1'b0;
    else       prevLow <= srcLow;
  end

  assign fallSeen = srcLow && !prevLow;

  always_comb begin
    strobe.setPend = fallSeen;
    strobe.clrPend = ack && !fallSeen;  // an edge wins over a coinciding ack
  end

  // R1: the edge detector reports nothing until the source has actually been low
  assert_no_phantom_edge_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setPend |-> srcLow);
endmodule

// File: rtl/extIntDatapath.sv
module extIntDatapath
  import extint_pkg::*;
#(
  parameter int NUM_PORT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irqPinN,
  input  logic [NUM_PORT-1:0] portPinN,
  input  logic [NUM_PORT-1:0] portEn,
  input  logic                levelMode,
  input  logic                cpuMask,
  input  pendStrobe_t         strobe,
  output logic                srcLow,
  output logic                irqReq
);
  localparam int NUM_SRC = NUM_PORT + 1;

  logic [NUM_SRC-1:0] rawN;
  logic [NUM_SRC-1:0] syncN;
  logic [NUM_SRC-1:0] useMask;
  logic               pending;

  assign rawN    = {portPinN, irqPinN};
  assign useMask = {portEn, 1'b1};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], rawN[i]};
    end
    assign syncN[i] = chain[SYNC_STAGES-1];
  end

  // wired-OR of active-low sources: low when any enabled source is low
  assign srcLow = |(~syncN & useMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pending <= 1'b0;
    else if (strobe.setPend) pending <= 1'b1;
    else if (strobe.clrPend) pending <= 1'b0;
  end

  assign irqReq = !cpuMask && (pending || (levelMode && srcLow));

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuMask |-> !irqReq);
  assert_edge_needs_pend_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!levelMode && !pending) |-> !irqReq);
  assert_level_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && srcLow && !cpuMask) |-> irqReq);
  assert_pend_from_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pending) |-> $past(srcLow));
  assert_edge_kept_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setPend |=> pending);
endmodule

// File: rtl/extIntCombiner.sv
module extIntCombiner
  import extint_pkg::*;
#(
  parameter int NUM_PORT    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                irqPinN,
  input  logic [NUM_PORT-1:0] portPinN,
  input  logic [NUM_PORT-1:0] portEn,
  input  logic                levelMode,
  input  logic                cpuMask,
  input  logic                ack,
  output logic                irqReq
);
  pendStrobe_t strobe;
  logic        srcLow;

  extIntDatapath #(.NUM_PORT(NUM_PORT), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .portPinN(portPinN),
    .portEn(portEn), .levelMode(levelMode), .cpuMask(cpuMask),
    .strobe(strobe), .srcLow(srcLow), .irqReq(irqReq)
  );

  extIntControl u_ctl (
    .clk(clk), .rstN(rstN), .srcLow(srcLow), .ack(ack), .strobe(strobe)
  );
endmodule

// File: tb/extIntCombiner_tb.sv
`timescale 1ns/1ps
module extIntCombiner_tb;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqPinN = 1'b1;
  logic [NP-1:0] portPinN = '1;
  logic [NP-1:0] portEn = '0;
  logic levelMode = 1'b0;
  logic cpuMask = 1'b0;
  logic ack = 1'b0;
  logic irqReq;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  extIntCombiner #(.NUM_PORT(NP), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .portPinN(portPinN),
    .portEn(portEn), .levelMode(levelMode), .cpuMask(cpuMask),
    .ack(ack), .irqReq(irqReq)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irqReq=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic pulseAck();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  task automatic clearAll();
    irqPinN = 1'b1;
    portPinN = '1;
    cyc(4);
    pulseAck();
    cyc(1);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    // R1: quiet after reset with all pins high
    for (int i = 0; i < 5; i++) begin
      cyc(1);
      check("R1 reset quiet", irqReq, 1'b0);
    end

    // R2: edge-mode latency on the dedicated pin
    irqPinN = 1'b0;
    cyc(2);
    check("R2 not yet after two edges", irqReq, 1'b0);
    cyc(1);
    check("R2 asserted after three edges", irqReq, 1'b1);
    // R7 and R3: ack clears, held low does not re-assert
    pulseAck();
    check("R7 ack clears", irqReq, 1'b0);
    cyc(3);
    check("R3 held low no re-assert", irqReq, 1'b0);
    irqPinN = 1'b1;
    cyc(4);
    check("R3 rising edge ignored", irqReq, 1'b0);

    // R4: level-mode latency
    levelMode = 1'b1;
    irqPinN = 1'b0;
    cyc(1);
    check("R4 not yet after one edge", irqReq, 1'b0);
    cyc(1);
    check("R4 asserted after two edges", irqReq, 1'b1);
    clearAll();
    check("R4 cleared once released", irqReq, 1'b0);
    levelMode = 1'b0;

    // R8: mask gates output but keeps pending
    irqPinN = 1'b0;
    cyc(1);
    cpuMask = 1'b1;
    cyc(4);
    check("R8 masked", irqReq, 1'b0);
    cpuMask = 1'b0;
    #0;
    cyc(1);
    check("R8 pending survives mask", irqReq, 1'b1);
    clearAll();

    // R9: a new edge coinciding with ack keeps pending set
    portEn = 4'b0001;
    portPinN[0] = 1'b0;
    cyc(3);
    portPinN[0] = 1'b1;
    cyc(3);
    check("R9 prior pending set", irqReq, 1'b1);
    irqPinN = 1'b0;
    cyc(2);
    pulseAck();  // ack sampled in the cycle the edge is detected
    check("R9 edge during ack kept", irqReq, 1'b1);
    pulseAck();
    check("R7 second ack clears", irqReq, 1'b0);
    clearAll();

    // R5/R6: sweep modes x enable patterns x port pin
    for (int m = 0; m < 2; m++) begin
      for (int en = 0; en < 16; en++) begin
        for (int k = 0; k < NP; k++) begin
          logic expOn;
          levelMode = m[0];
          portEn = en[NP-1:0];
          clearAll();
          expOn = en[k];
          portPinN[k] = 1'b0;
          cyc(3);
          check("R5 port merge by enable", irqReq, expOn);
          pulseAck();
          check("R6 mode applies to port pin", irqReq, expOn & m[0]);
          portPinN[k] = 1'b1;
          cyc(3);
          check("R3 release no request", irqReq, 1'b0);
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule